// File: doc/BRIEF.md
# Latched Interrupt Sequencer with Return Stack

This block sits beside an instruction sequencer. It captures an external interrupt request, keeps it pending, and decides at each instruction boundary whether the request may be taken. When it takes the request, it raises a redirect strobe in the same cycle and presents the fixed vector address. It also reports the cycle cost of the redirect. On the following clock edge it sets the interrupt mask and saves the current program counter on its return stack.

The same four-entry return stack serves call, return and accumulator push/pop instructions through plain push and pop strobes. The interface has no back-pressure: a strobe acts on the clock edge that samples it, and the stack never refuses an operation. Overfilling the stack silently discards the oldest entry. Popping keeps the bottom entry in place, so the bottom value is duplicated. The mask bit is driven by enable and disable strobes from the decoder.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the mask bit is 1, the stack top reads 0, and no redirect is raised at any boundary.
- R2: A rising edge on `irq_req` sets a pending request. The request stays pending after the pin falls and is cleared only by servicing.
- R3: A pending request is taken at a boundary only while the mask bit is 0. A request that arrives while masked is taken at the first allowed boundary after the mask clears.
- R4: The request is withheld at a boundary whose `prev_op` meets any of these conditions: high byte equal to 0x6D; bits 15..13 equal to 3'b100; the whole word equal to 0x7F82. Every other opcode, including 0x7F81, allows servicing.
- R5: Servicing has three effects on the next edge. The mask bit becomes 1, the pending request is cleared, and `cur_pc` is pushed so that it becomes the stack top.
- R6: In a servicing cycle `vec_take` is 1, `vec_pc` is 0x002 and `svc_cycles` is 3. In every other cycle `vec_take` is 0 and `svc_cycles` is 0.
- R7: A push moves every entry one place down and writes the new value on top, discarding the fifth-oldest value. A pop moves every entry one place up and leaves the bottom entry unchanged.
- R8: Pushed values are truncated to their low 12 bits.
- R9: In a servicing cycle the `push_en` and `pop_en` strobes are ignored. Only `cur_pc` is pushed.
- R10: `set_mask` sets the mask bit. `clr_mask` clears it, except in a servicing cycle, where the mask becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | External request pin; a rising edge latches a request |
| boundary | input | 1 | Instruction boundary strobe |
| prev_op | input | 16 | Opcode of the instruction just completed |
| cur_pc | input | 12 | Program counter to save on servicing |
| push_en | input | 1 | Push strobe |
| push_data | input | 16 | Value to push; low 12 bits kept |
| pop_en | input | 1 | Pop strobe |
| set_mask | input | 1 | Disable-interrupts strobe |
| clr_mask | input | 1 | Enable-interrupts strobe |
| vec_take | output | 1 | Redirect fetch to the vector this cycle |
| vec_pc | output | 12 | Vector address |
| svc_cycles | output | 2 | Cycle cost of the redirect |
| stack_top | output | 12 | Top stack entry |
| mask_bit | output | 1 | Interrupt mask status |

## Verification
The hardest state to reach is a request that is pending and unmasked while the opcode at the boundary blocks servicing. Such a request must survive that boundary and be taken at the next one. To reach this state, the bench latches a request and clears the mask for each of the 256 opcode high bytes in turn. It then presents a boundary carrying that opcode and compares the redirect with a decode computed arithmetically. After each withheld case it presents a neutral boundary, where the request must now be taken.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam logic [7:0]  MUL_MEM_HI = 8'h6D;
  localparam logic [2:0]  MUL_IMM_TOP = 3'b100;
  localparam logic [15:0] ENA_INT_OP = 16'h7F82;

  function automatic logic op_blocks_service(input logic [15:0] op);
    return (op[15:8] == MUL_MEM_HI) || (op[15:13] == MUL_IMM_TOP) || (op == ENA_INT_OP);
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic take,
  output logic pending
);
  logic req_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_d   <= irq_req;
      pending <= (pending & ~take) | (irq_req & ~req_d);
    end
  end
endmodule

// File: rtl/irq_mask.sv
module irq_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic set_mask,
  input  logic clr_mask,
  output logic mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 mask <= 1'b1;
    else if (take || set_mask)  mask <= 1'b1;
    else if (clr_mask)          mask <= 1'b0;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] top
);
  logic [AW-1:0] ent [DEPTH];
  logic [AW-1:0] din_m;

  assign din_m = din[AW-1:0];
  assign top   = ent[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] from_above;
    logic [AW-1:0] from_below;
    if (i == 0) begin : g_first
      assign from_above = din_m;
    end else begin : g_rest
      assign from_above = ent[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_below = ent[i];
    end else begin : g_mid
      assign from_below = ent[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    ent[i] <= '0;
      else if (push) ent[i] <= from_above;
      else if (pop)  ent[i] <= from_below;
    end
  end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 16,
  parameter int unsigned CW       = 2,
  parameter int unsigned SVC_COST = 3,
  parameter logic [AW-1:0] VECTOR = 12'h002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          boundary,
  input  logic [15:0]   prev_op,
  input  logic [AW-1:0] cur_pc,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  input  logic          set_mask,
  input  logic          clr_mask,
  output logic          vec_take,
  output logic [AW-1:0] vec_pc,
  output logic [CW-1:0] svc_cycles,
  output logic [AW-1:0] stack_top,
  output logic          mask_bit
);
  import irq_seq_pkg::*;

  logic          pending;
  logic          take;
  logic          stk_push;
  logic          stk_pop;
  logic [DW-1:0] stk_din;

  assign take = boundary & pending & ~mask_bit & ~op_blocks_service(prev_op);

  irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .take(take), .pending(pending)
  );

  irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .take(take), .set_mask(set_mask),
    .clr_mask(clr_mask), .mask(mask_bit)
  );

  assign stk_push = take | push_en;
  assign stk_pop  = pop_en & ~take;
  assign stk_din  = take ? {{(DW-AW){1'b0}}, cur_pc} : push_data;

  ret_stack #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .din(stk_din), .top(stack_top)
  );

  assign vec_take   = take;
  assign vec_pc     = VECTOR;
  assign svc_cycles = take ? CW'(SVC_COST) : '0;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic [15:0]   prev_op,
  input logic [AW-1:0] cur_pc,
  input logic          push_en,
  input logic [DW-1:0] push_data,
  input logic          pop_en,
  input logic          set_mask,
  input logic          clr_mask,
  input logic          vec_take,
  input logic [CW-1:0] svc_cycles,
  input logic [AW-1:0] stack_top,
  input logic          mask_bit
);
  // R5
  take_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> mask_bit);
  // R5
  take_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> stack_top == $past(cur_pc));
  // R10
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask |=> mask_bit);
  // R10
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask && !set_mask && !vec_take) |=> !mask_bit);
  // R8
  push_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !vec_take) |=> stack_top == $past(push_data[AW-1:0]));
  // R4
  eint_withhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && prev_op == 16'h7F82) |-> !vec_take);
  // R6
  cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> svc_cycles == CW'(3));
  // R3
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_bit |-> !vec_take);
  // R7
  pop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !pop_en && !vec_take) |=> $stable(stack_top));
endmodule

bind irq_seq_top irq_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .prev_op(prev_op),
  .cur_pc(cur_pc), .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
  .set_mask(set_mask), .clr_mask(clr_mask), .vec_take(vec_take),
  .svc_cycles(svc_cycles), .stack_top(stack_top), .mask_bit(mask_bit)
);

// File: tb/test_irq_seq_top.sv
module test_irq_seq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        boundary = 1'b0;
  logic [15:0] prev_op = '0;
  logic [11:0] cur_pc = '0;
  logic        push_en = 1'b0;
  logic [15:0] push_data = '0;
  logic        pop_en = 1'b0;
  logic        set_mask = 1'b0;
  logic        clr_mask = 1'b0;
  logic        vec_take;
  logic [11:0] vec_pc;
  logic [1:0]  svc_cycles;
  logic [11:0] stack_top;
  logic        mask_bit;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_seq_top i_irq_seq_top (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .boundary(boundary),
    .prev_op(prev_op), .cur_pc(cur_pc), .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .set_mask(set_mask), .clr_mask(clr_mask),
    .vec_take(vec_take), .vec_pc(vec_pc), .svc_cycles(svc_cycles),
    .stack_top(stack_top), .mask_bit(mask_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    irq_req = 0; boundary = 0; prev_op = '0; push_en = 0; pop_en = 0;
    set_mask = 0; clr_mask = 0;
  endtask

  task automatic do_push(input logic [15:0] v);
    nxt(); push_en = 1; push_data = v;
  endtask

  task automatic do_pop();
    nxt(); pop_en = 1;
  endtask

  task automatic settle();
    nxt(); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic exp_ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    nxt(); boundary = 1; #1;
    chk("R1 mask after reset", mask_bit, 1);
    chk("R1 stack top after reset", stack_top, 0);
    chk("R1 no redirect after reset", vec_take, 0);

    // R2/R3: request while masked stays pending after pin drops
    nxt(); irq_req = 1;
    nxt();
    for (int k = 0; k < 3; k++) begin
      nxt(); boundary = 1; #1;
      chk("R3 masked request not taken", vec_take, 0);
    end
    nxt(); clr_mask = 1;
    nxt(); #1;
    chk("R10 clr_mask clears mask", mask_bit, 0);
    boundary = 1; cur_pc = 12'h345; #1;
    chk("R2 pending survives pin drop, taken after unmask", vec_take, 1);
    chk("R6 vector address", vec_pc, 12'h002);
    chk("R6 service cost", svc_cycles, 3);
    settle();
    chk("R5 mask set by service", mask_bit, 1);
    chk("R5 pc pushed", stack_top, 12'h345);
    chk("R6 no cost outside service", svc_cycles, 0);

    // R5: pending cleared
    nxt(); clr_mask = 1;
    nxt(); boundary = 1; #1;
    chk("R5 pending cleared by service", vec_take, 0);

    // R4 sweep over every opcode high byte
    for (int hb = 0; hb < 256; hb++) begin
      nxt(); irq_req = 1;
      nxt(); clr_mask = 1;
      nxt(); boundary = 1; cur_pc = 12'(hb + 12'h100);
      prev_op = {8'(hb), (hb == 8'h7F) ? 8'h82 : 8'h00};
      exp_ok = !((hb == 8'h6D) || (hb[7:5] == 3'b100) || (hb == 8'h7F));
      #1;
      chk($sformatf("R4 opcode %04h gating", prev_op), vec_take, exp_ok);
      if (!exp_ok) begin
        nxt(); boundary = 1; cur_pc = 12'(hb + 12'h100); #1;
        chk("R3 withheld request taken at next allowed boundary", vec_take, 1);
      end
      settle();
      chk("R5 pc pushed in sweep", stack_top, 12'(hb + 12'h100));
    end
    nxt(); irq_req = 1;
    nxt(); clr_mask = 1;
    nxt(); boundary = 1; prev_op = 16'h7F81; cur_pc = 12'h0AA; #1;
    chk("R4 opcode 7F81 allows service", vec_take, 1);

    // R10: set/clear and priority of service over clr_mask
    nxt(); set_mask = 0;
    nxt(); clr_mask = 1;
    nxt(); set_mask = 1;
    settle();
    chk("R10 set_mask sets mask", mask_bit, 1);
    nxt(); clr_mask = 1;
    nxt(); irq_req = 1;
    nxt(); boundary = 1; clr_mask = 1; cur_pc = 12'h0CC; #1;
    chk("R3 taken while unmasked", vec_take, 1);
    settle();
    chk("R10 service beats clr_mask", mask_bit, 1);

    // R9: push/pop ignored during service
    do_push(16'h0111);
    nxt(); clr_mask = 1;
    nxt(); irq_req = 1;
    nxt(); boundary = 1; cur_pc = 12'h0AA; push_en = 1; push_data = 16'h0555;
    settle();
    chk("R9 push ignored in service", stack_top, 12'h0AA);
    do_pop(); settle();
    chk("R9 stack below service entry", stack_top, 12'h111);
    do_push(16'h0222);
    nxt(); clr_mask = 1;
    nxt(); irq_req = 1;
    nxt(); boundary = 1; cur_pc = 12'h0BB; pop_en = 1;
    settle();
    chk("R9 pop ignored in service", stack_top, 12'h0BB);
    do_pop(); settle();
    chk("R9 entry under service kept", stack_top, 12'h222);

    // R7: overfill and pop duplication
    for (int k = 1; k <= 5; k++) begin
      do_push(16'(12'h100 + k)); settle();
      chk("R7 push top", stack_top, 12'h100 + k);
    end
    for (int k = 4; k >= 2; k--) begin
      do_pop(); settle();
      chk("R7 pop order", stack_top, 12'h100 + k);
    end
    do_pop(); settle();
    chk("R7 bottom duplicated, oldest lost", stack_top, 12'h102);
    do_pop(); settle();
    chk("R7 bottom still duplicated", stack_top, 12'h102);

    // R8: truncation
    do_push(16'hF7C3); settle();
    chk("R8 push truncated to 12 bits", stack_top, 12'h7C3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule